// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

This block is a memory-mapped timer. One up-counter advances by one on each cycle in which the reference tick input is high. Next to it sit a set of match channels, each holding a compare value. When the counter lands on a channel's compare value and that channel is enabled, the channel latches a sticky status flag and drives its own interrupt line. Software acknowledges an interrupt by writing ones to the status register.

The highest-numbered channel has a second job as a one-shot watchdog. If the arm bit is set when that channel matches, the block pulses a reset-request output for one cycle and clears the arm bit itself. Software must re-arm it before the next match to get another reset request.

Bus accesses are single-cycle strobes. Read data and the error flag come back registered, on the clock edge after the access. An offset that is not in the map returns zero and raises the error flag.

Top module: `match_wdog_timer`

## Requirements
- R1: After reset the counter, every compare value, the status flags, the interrupt-enable bits and the watchdog arm bit are all zero, and `irq_o` and `rst_req_o` are low.
- R2: The counter rises by one on every clock edge at which `tick_i` is high. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the counter with the write data, and counting continues from that value. When a load and a tick fall in the same cycle, the load wins.
- R4: A channel detects a match when the counter has just been updated (by tick or by load) onto its compare value. If the channel's enable bit is set, its status bit and `irq_o` bit go high on the clock edge after that detection. The compare values sit at offsets 0x00, 0x04, 0x08 and 0x0C for channels 0 to 3.
- R5: A match on a channel whose enable bit is clear changes neither its status bit nor its interrupt line.
- R6: The status register at 0x14 is write-one-to-clear, with bit i belonging to channel i. A 1 in bit i clears that status bit and drops `irq_o[i]`. A 0 leaves the bit unchanged.
- R7: If a match and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R8: Bit 0 of offset 0x18 is the watchdog arm bit. If it is set when channel 3 matches, `rst_req_o` is high for exactly one cycle (the edge after detection) and the arm bit clears itself. This happens whatever the state of channel 3's interrupt enable. Without the arm bit set, a channel-3 match gives no reset request.
- R9: Offset 0x1C holds the interrupt-enable bits 3..0, with bit i belonging to channel i. Upper write bits are dropped. Offset 0x18 keeps only bit 0. Reads return the register value on `bus_rdata_o` one edge after the access.
- R10: An access to any other offset, including an address that is not word aligned, returns zero and raises `bus_err_o` for one cycle, one edge after the access.
- R11: Matching is modulo 2^32. A compare value just past the wrap point fires once the counter has wrapped to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick; counter advances on edges where high |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, zero when not a mapped read |
| bus_err_o | output | 1 | One-cycle flag for an unmapped offset |
| irq_o | output | 4 | Per-channel interrupt lines |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit counter, an 8-bit offset and channel 3 as the watchdog. With the full counter width, the wrap case is reached by loading the counter two steps below 2^32 instead of waiting 2^32 ticks. With four channels the whole match-register window is populated, so the unmapped checks land just past the map and on a misaligned offset. The one-cycle detect-to-flag latency and the match-versus-clear race are hit by issuing the write in the exact cycle after the tick edge.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

   // Fixed register offsets; the match window starts at zero with 4-byte stride.
   localparam logic [7:0] OFS_MATCH0 = 8'h00;
   localparam logic [7:0] OFS_COUNT  = 8'h10;
   localparam logic [7:0] OFS_STATUS = 8'h14;
   localparam logic [7:0] OFS_ARM    = 8'h18;
   localparam logic [7:0] OFS_IEN    = 8'h1C;
   localparam int unsigned MAX_CH    = 4;

   // Write strobes for the scalar registers.
   typedef struct packed {
      logic cnt;
      logic stat;
      logic arm;
      logic ien;
   } wr_strb_t;

endpackage

// File: rtl/mwt_counter.sv
module mwt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fresh_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         // A load takes priority over a tick in the same cycle.
         if (load_i) begin
            cnt_q <= load_val_i;
         end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         fresh_q <= load_i | tick_i;
      end
   end

   assign cnt_o   = cnt_q;
   assign fresh_o = fresh_q;

endmodule

// File: rtl/mwt_channel.sv
module mwt_channel #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             match_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             fresh_i,
   input  logic             ien_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] match_o,
   output logic             hit_o,
   output logic             status_o
);

   logic [CNT_W-1:0] match_q;
   logic             status_q;

   // A hit only counts when the counter has just moved onto the value.
   assign hit_o = fresh_i && (cnt_i == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
      end else if (match_we_i) begin
         match_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (hit_o && ien_i) begin
         status_q <= 1'b1;          // a new match beats a clearing write
      end else if (clr_i) begin
         status_q <= 1'b0;
      end
   end

   assign match_o  = match_q;
   assign status_o = status_q;

endmodule

// File: rtl/mwt_wdog.sv
module mwt_wdog (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic we_i,
   input  logic wbit_i,
   output logic arm_o,
   output logic rst_req_o
);

   logic arm_q;
   logic req_q;
   logic fire;

   assign fire = hit_i && arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         req_q <= 1'b0;
      end else begin
         req_q <= fire;
         if (fire) begin
            arm_q <= 1'b0;          // one-shot: disarm on firing
         end else if (we_i) begin
            arm_q <= wbit_i;
         end
      end
   end

   assign arm_o     = arm_q;
   assign rst_req_o = req_q;

endmodule

// File: rtl/mwt_regif.sv
module mwt_regif
   import mwt_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sel_i,
   input  logic                          wr_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [CNT_W-1:0]              cnt_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  match_i,
   input  logic [NUM_CH-1:0]             status_i,
   input  logic [NUM_CH-1:0]             ien_i,
   input  logic                          arm_i,
   output wr_strb_t                      strb_o,
   output logic [NUM_CH-1:0]             match_we_o,
   output logic [DATA_W-1:0]             rdata_o,
   output logic                          err_o
);

   logic              mapped;
   logic [DATA_W-1:0] rd_val;
   logic              is_cnt, is_stat, is_arm, is_ien;
   logic [NUM_CH-1:0] is_match;

   assign is_cnt  = (addr_i == ADDR_W'(OFS_COUNT));
   assign is_stat = (addr_i == ADDR_W'(OFS_STATUS));
   assign is_arm  = (addr_i == ADDR_W'(OFS_ARM));
   assign is_ien  = (addr_i == ADDR_W'(OFS_IEN));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_mdec
      assign is_match[g] = (addr_i == ADDR_W'(OFS_MATCH0) + ADDR_W'(4 * g));
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (is_match[i]) rd_val = DATA_W'(match_i[i]);
      end
      if (is_cnt)  rd_val = DATA_W'(cnt_i);
      if (is_stat) rd_val = DATA_W'(status_i);
      if (is_arm)  rd_val = DATA_W'(arm_i);
      if (is_ien)  rd_val = DATA_W'(ien_i);
   end

   assign mapped = (|is_match) | is_cnt | is_stat | is_arm | is_ien;

   always_comb begin
      strb_o.cnt  = sel_i && wr_i && is_cnt;
      strb_o.stat = sel_i && wr_i && is_stat;
      strb_o.arm  = sel_i && wr_i && is_arm;
      strb_o.ien  = sel_i && wr_i && is_ien;
      match_we_o  = (sel_i && wr_i) ? is_match : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         rdata_o <= (sel_i && !wr_i && mapped) ? rd_val : '0;
         err_o   <= sel_i && !mapped;
      end
   end

endmodule

// File: rtl/match_wdog_timer.sv
module match_wdog_timer
   import mwt_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WDOG_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              bus_err_o,
   output logic [NUM_CH-1:0] irq_o,
   output logic              rst_req_o
);

   // Elaboration-time parameter checks.
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("match_wdog_timer: NUM_CH must lie in 1..4");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cw
      $error("match_wdog_timer: CNT_W must lie in 2..DATA_W");
   end
   if (WDOG_CH >= NUM_CH) begin : g_bad_wd
      $error("match_wdog_timer: WDOG_CH must name an existing channel");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("match_wdog_timer: ADDR_W too narrow for the register map");
   end

   wr_strb_t                      strb;
   logic [NUM_CH-1:0]             match_we;
   logic [CNT_W-1:0]              cnt;
   logic                          fresh;
   logic                          cnt_load;
   logic [NUM_CH-1:0][CNT_W-1:0]  match_val;
   logic [NUM_CH-1:0]             hit;
   logic [NUM_CH-1:0]             status;
   logic [NUM_CH-1:0]             stat_clr;
   logic [NUM_CH-1:0]             ien_q;
   logic                          arm;

   assign cnt_load = strb.cnt;
   assign stat_clr = strb.stat ? bus_wdata_i[NUM_CH-1:0] : '0;

   mwt_regif #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (bus_sel_i),
      .wr_i       (bus_wr_i),
      .addr_i     (bus_addr_i),
      .cnt_i      (cnt),
      .match_i    (match_val),
      .status_i   (status),
      .ien_i      (ien_q),
      .arm_i      (arm),
      .strb_o     (strb),
      .match_we_o (match_we),
      .rdata_o    (bus_rdata_o),
      .err_o      (bus_err_o)
   );

   mwt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (cnt_load),
      .load_val_i (bus_wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt),
      .fresh_o    (fresh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (strb.ien) begin
         ien_q <= bus_wdata_i[NUM_CH-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mwt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .match_we_i (match_we[c]),
         .wdata_i    (bus_wdata_i[CNT_W-1:0]),
         .cnt_i      (cnt),
         .fresh_i    (fresh),
         .ien_i      (ien_q[c]),
         .clr_i      (stat_clr[c]),
         .match_o    (match_val[c]),
         .hit_o      (hit[c]),
         .status_o   (status[c])
      );
   end

   mwt_wdog u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit[WDOG_CH]),
      .we_i      (strb.arm),
      .wbit_i    (bus_wdata_i[0]),
      .arm_o     (arm),
      .rst_req_o (rst_req_o)
   );

   assign irq_o = status;

endmodule

// File: rtl/mwt_checker.sv
module mwt_checker #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              cnt_load,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [NUM_CH-1:0] hit,
   input logic [NUM_CH-1:0] ien,
   input logic [NUM_CH-1:0] stat_clr,
   input logic [NUM_CH-1:0] irq,
   input logic              arm,
   input logic              rst_req,
   input logic              err,
   input logic [DATA_W-1:0] rdata
);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cnt_load) |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> (cnt == $past(wdata[CNT_W-1:0])));

   assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!arm && $past(arm)));

   assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[c]) |-> $past(ien[c]));

      assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[c] && ien[c]) |=> irq[c]);

      assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_clr[c] && !(hit[c] && ien[c])) |=> !irq[c]);

      assert_match_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_clr[c] && hit[c] && ien[c]) |=> irq[c]);
   end

endmodule

bind match_wdog_timer mwt_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .cnt_load (cnt_load),
   .wdata    (bus_wdata_i),
   .cnt      (cnt),
   .hit      (hit),
   .ien      (ien_q),
   .stat_clr (stat_clr),
   .irq      (irq_o),
   .arm      (arm),
   .rst_req  (rst_req_o),
   .err      (bus_err_o),
   .rdata    (bus_rdata_o)
);

// File: tb/match_wdog_timer_tb.sv
module match_wdog_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_sel_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [7:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        bus_err_o;
   logic [3:0]  irq_o;
   logic        rst_req_o;

   int n_chk  = 0;
   int n_fail = 0;
   int pulses = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   match_wdog_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .bus_sel_i   (bus_sel_i),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .bus_err_o   (bus_err_o),
      .irq_o       (irq_o),
      .rst_req_o   (rst_req_o)
   );

   always @(negedge clk) if (rst_n && rst_req_o) pulses++;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;   // write data, or expected read data
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 32'h0,        1'b0, 4'd1},   // R1 compare 0
      '{1'b0, 8'h10, 32'h0,        1'b0, 4'd1},   // R1 counter
      '{1'b0, 8'h14, 32'h0,        1'b0, 4'd1},   // R1 status
      '{1'b0, 8'h18, 32'h0,        1'b0, 4'd1},   // R1 arm
      '{1'b0, 8'h1C, 32'h0,        1'b0, 4'd1},   // R1 enables
      '{1'b0, 8'h08, 32'h0,        1'b0, 4'd1},   // R1 compare 2
      '{1'b1, 8'h1C, 32'hFFF,      1'b0, 4'd9},   // R9 upper bits dropped
      '{1'b0, 8'h1C, 32'hF,        1'b0, 4'd9},
      '{1'b1, 8'h04, 32'hDEADBEEF, 1'b0, 4'd9},   // R9 compare 1
      '{1'b0, 8'h04, 32'hDEADBEEF, 1'b0, 4'd9},
      '{1'b1, 8'h0C, 32'h12345678, 1'b0, 4'd9},   // R9 compare 3
      '{1'b0, 8'h0C, 32'h12345678, 1'b0, 4'd9},
      '{1'b0, 8'h20, 32'h0,        1'b1, 4'd10},  // R10 past the map
      '{1'b0, 8'h02, 32'h0,        1'b1, 4'd10},  // R10 misaligned
      '{1'b1, 8'h40, 32'h0,        1'b1, 4'd10},  // R10 write unmapped
      '{1'b1, 8'h18, 32'hFFFFFFFE, 1'b0, 4'd9},   // R9 arm keeps bit 0 only
      '{1'b0, 8'h18, 32'h0,        1'b0, 4'd9},
      '{1'b1, 8'h1C, 32'h0,        1'b0, 4'd9},
      '{1'b0, 8'h1C, 32'h0,        1'b0, 4'd9}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic access(input logic wr, input logic [7:0] addr,
                         input logic [31:0] data,
                         output logic [31:0] rd, output logic err);
      bus_sel_i   = 1'b1;
      bus_wr_i    = wr;
      bus_addr_i  = addr;
      bus_wdata_i = data;
      @(negedge clk);
      rd = bus_rdata_o;
      err = bus_err_o;
      bus_sel_i = 1'b0;
      bus_wr_i  = 1'b0;
   endtask

   task automatic wr(input logic [7:0] addr, input logic [31:0] data);
      logic [31:0] d;
      logic e;
      access(1'b1, addr, data, d, e);
   endtask

   task automatic rd_chk(input logic [7:0] addr, input logic [31:0] exp,
                         input string req);
      logic [31:0] d;
      logic e;
      access(1'b0, addr, 32'h0, d, e);
      check(d == exp && !e, req, d, exp);
   endtask

   task automatic ticks(input int n);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 outputs after reset
      check(irq_o == 4'b0, "R1 irq", 32'(irq_o), 32'h0);
      check(rst_req_o == 1'b0, "R1 rst_req", 32'(rst_req_o), 32'h0);

      // Table of register accesses (R1, R9, R10)
      for (int i = 0; i < NV; i++) begin
         access(VEC[i].wr, VEC[i].addr, VEC[i].data, d, e);
         n_chk++;
         if (e != VEC[i].err || (!VEC[i].wr && d != VEC[i].data)) begin
            n_fail++;
            $display("FAIL R%0d entry %0d actual=%h/%b expected=%h/%b",
                     VEC[i].req, i, d, e, VEC[i].data, VEC[i].err);
         end
      end

      // R2: counting from a loaded value
      wr(8'h10, 32'd100);
      ticks(5);
      rd_chk(8'h10, 32'd105, "R2 count");

      // R3: load wins over a simultaneous tick
      tick_i = 1'b1;
      wr(8'h10, 32'd500);
      tick_i = 1'b0;
      rd_chk(8'h10, 32'd500, "R3 load priority");

      // R4 / R5: channel 0 enabled, channel 1 disabled, both compare at 503
      wr(8'h1C, 32'h1);
      wr(8'h00, 32'd503);
      wr(8'h04, 32'd503);
      ticks(3);
      check(irq_o == 4'b0000, "R4 latency", 32'(irq_o), 32'h0);
      idle(1);
      check(irq_o == 4'b0001, "R4 R5 irq", 32'(irq_o), 32'h1);
      rd_chk(8'h14, 32'h1, "R4 R5 status");

      // R6: zero write has no effect, one write clears
      wr(8'h14, 32'h0);
      check(irq_o == 4'b0001, "R6 zero write", 32'(irq_o), 32'h1);
      wr(8'h14, 32'h1);
      check(irq_o == 4'b0000, "R6 clear", 32'(irq_o), 32'h0);
      rd_chk(8'h14, 32'h0, "R6 status");

      // R7: clear lands in the detection cycle; the match wins
      wr(8'h00, 32'd505);
      ticks(2);
      wr(8'h14, 32'h1);
      check(irq_o == 4'b0001, "R7 match wins", 32'(irq_o), 32'h1);
      wr(8'h14, 32'h1);

      // R11: wrap-around match on channel 2
      wr(8'h1C, 32'h4);
      wr(8'h08, 32'h1);
      wr(8'h10, 32'hFFFFFFFE);
      ticks(3);
      idle(1);
      check(irq_o == 4'b0100, "R11 wrap match", 32'(irq_o), 32'h4);
      rd_chk(8'h10, 32'h1, "R2 wrap");
      wr(8'h14, 32'h4);

      // R8: watchdog with channel 3 interrupt disabled
      wr(8'h1C, 32'h0);
      wr(8'h18, 32'h1);
      rd_chk(8'h18, 32'h1, "R8 armed");
      wr(8'h0C, 32'd3);
      ticks(2);
      check(rst_req_o == 1'b0, "R8 before", 32'(rst_req_o), 32'h0);
      idle(1);
      check(rst_req_o == 1'b1, "R8 pulse", 32'(rst_req_o), 32'h1);
      idle(1);
      check(rst_req_o == 1'b0, "R8 width", 32'(rst_req_o), 32'h0);
      check(pulses == 1, "R8 count", 32'(pulses), 32'h1);
      rd_chk(8'h18, 32'h0, "R8 disarm");
      rd_chk(8'h14, 32'h0, "R5 ch3 status");
      check(irq_o == 4'b0, "R5 ch3 irq", 32'(irq_o), 32'h0);

      // R8: unarmed match gives no request
      wr(8'h0C, 32'd5);
      ticks(2);
      idle(2);
      check(pulses == 1, "R8 one-shot", 32'(pulses), 32'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule